// File: doc/BRIEF.md
# Binary-Tree Node Exchange Sequencer

Each node of a four-level binary tree owns a small slice of switch control: a direction bit, where 1 means the node transmits and 0 means it receives, and the address of the peer it is connected to. This block drives that slice for one node through one round of a tree reduction. The node's level and the addresses of its left child, right child and parent are captured when a round starts. The block then presents the peer connections in a fixed order. The node receives first from the left child, then from the right child, and finally transmits to the parent. The transfer engine reports the end of each transfer with a one-cycle completion input.

A node at level 3 is a leaf. It has no children, so it goes straight to transmitting. The node at level 0 is the root. It receives from its single level-1 child, which is given on the left-child input, and it never transmits. When the last transfer ends, the block pulses a done output for one cycle. It then returns to idle and waits for the next start.

Top module: `tree_node_seq`

## Requirements
- R1: While `rst` is high, and in idle after reset, `tr_o` is 0, `addr_o` is 0 and `done_o` is 0. Reset is synchronous and active high, and it also abandons a round in progress.
- R2: For a level of 1 or 2, a round presents three steps in order: `tr_o`=0 with the left address, then `tr_o`=0 with the right address, then `tr_o`=1 with the parent address.
- R3: For level 3 (a leaf), the round has one step, `tr_o`=1 with the parent address. `tr_o` is never 0 during that round.
- R4: For level 0 (the root), the round has one step, `tr_o`=0 with the left address. `tr_o` is never 1 during that round.
- R5: The first step appears on the outputs in the cycle after the clock edge that samples `start`. Each later step appears in the cycle after the edge that samples `xfer_done` high. While `xfer_done` is low, the outputs do not change.
- R6: After the final step's `xfer_done`, `done_o` is 1 for exactly one cycle, and during that cycle `tr_o` and `addr_o` keep the final step's values. In the next cycle the block is idle, with `tr_o`=0 and `addr_o`=0.
- R7: `start` is ignored outside idle, including in the cycle in which `done_o` is high.
- R8: `xfer_done` is ignored in idle, including in the same cycle as `start`.
- R9: The level and the three addresses are taken only at the `start` edge. Changing them during a round has no effect on that round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a round (taken in idle only) |
| level_i | input | LEVEL_W | Tree level of this node: 0 is the root, 3 is a leaf |
| left_i | input | ADDR_W | Left child address (the only child for the root) |
| right_i | input | ADDR_W | Right child address |
| parent_i | input | ADDR_W | Parent address |
| xfer_done | input | 1 | Current transfer finished |
| tr_o | output | 1 | Direction bit: 1 means transmit, 0 means receive |
| addr_o | output | ADDR_W | Peer address to load into the control slice |
| done_o | output | 1 | One-cycle end-of-round pulse |

## Verification
Two pairs of events can coincide. The first is `start` together with `xfer_done` in idle. The bench raises both on the same edge and expects the left step to appear and then stay put, because a completion seen in idle must not advance the round. The second is a new `start` during the one cycle in which `done_o` is high. The bench raises `start` exactly in that cycle and expects idle outputs on the following cycle, not a fresh round. A `start` pulse in the middle of a round and address changes after the start edge are checked the same way: the bench watches for any disturbance of the step being shown on `tr_o` and `addr_o`.

// File: rtl/tree_seq_pkg.sv
package tree_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RX_L = 3'd1,
    ST_RX_R = 3'd2,
    ST_TX_P = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/tree_seq_cfg.sv
// Captures the node's role and peer addresses at round start. During the
// capture cycle the live inputs are forwarded, so the first step can be
// loaded on the same edge that latches them.
module tree_seq_cfg #(
  parameter int ADDR_W  = 4,
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [ADDR_W-1:0]  left_i,
  input  logic [ADDR_W-1:0]  right_i,
  input  logic [ADDR_W-1:0]  parent_i,
  output logic               is_root,
  output logic               is_leaf,
  output logic [ADDR_W-1:0]  left_eff,
  output logic [ADDR_W-1:0]  right_eff,
  output logic [ADDR_W-1:0]  parent_eff
);
  localparam logic [LEVEL_W-1:0] LEAF_LEVEL = {LEVEL_W{1'b1}};
  localparam logic [LEVEL_W-1:0] ROOT_LEVEL = '0;

  logic              root_q, leaf_q;
  logic [ADDR_W-1:0] left_q, right_q, parent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q   <= 1'b0;
      leaf_q   <= 1'b0;
      left_q   <= '0;
      right_q  <= '0;
      parent_q <= '0;
    end else if (capture) begin
      root_q   <= (level_i == ROOT_LEVEL);
      leaf_q   <= (level_i == LEAF_LEVEL);
      left_q   <= left_i;
      right_q  <= right_i;
      parent_q <= parent_i;
    end
  end

  always_comb begin
    if (capture) begin
      is_root    = (level_i == ROOT_LEVEL);
      is_leaf    = (level_i == LEAF_LEVEL);
      left_eff   = left_i;
      right_eff  = right_i;
      parent_eff = parent_i;
    end else begin
      is_root    = root_q;
      is_leaf    = leaf_q;
      left_eff   = left_q;
      right_eff  = right_q;
      parent_eff = parent_q;
    end
  end
endmodule

// File: rtl/tree_seq_fsm.sv
module tree_seq_fsm
  import tree_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       xfer_done,
  input  logic       is_root,
  input  logic       is_leaf,
  output logic       capture,
  output seq_state_t state_q,
  output seq_state_t state_nxt
);
  assign capture = (state_q == ST_IDLE) && start;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (start)     state_nxt = is_leaf ? ST_TX_P : ST_RX_L;
      ST_RX_L: if (xfer_done) state_nxt = is_root ? ST_DONE : ST_RX_R;
      ST_RX_R: if (xfer_done) state_nxt = ST_TX_P;
      ST_TX_P: if (xfer_done) state_nxt = ST_DONE;
      ST_DONE:                state_nxt = ST_IDLE;
      default:                state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

  // R5
  hold_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RX_L || state_q == ST_RX_R || state_q == ST_TX_P) && !xfer_done)
      |=> $stable(state_q));

  // R7
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R3
  leaf_no_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX_L || state_q == ST_RX_R) |-> !is_leaf);
endmodule

// File: rtl/tree_seq_out.sv
// Registered control-slice outputs, decoded from the next state.
module tree_seq_out
  import tree_seq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state_nxt,
  input  logic [ADDR_W-1:0] left_eff,
  input  logic [ADDR_W-1:0] right_eff,
  input  logic [ADDR_W-1:0] parent_eff,
  output logic              tr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tr_o   <= 1'b0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= (state_nxt == ST_DONE);
      unique case (state_nxt)
        ST_RX_L: begin tr_o <= 1'b0; addr_o <= left_eff;   end
        ST_RX_R: begin tr_o <= 1'b0; addr_o <= right_eff;  end
        ST_TX_P: begin tr_o <= 1'b1; addr_o <= parent_eff; end
        ST_DONE: begin tr_o <= tr_o; addr_o <= addr_o;     end
        default: begin tr_o <= 1'b0; addr_o <= '0;         end
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/tree_node_seq.sv
module tree_node_seq
  import tree_seq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LEVEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [ADDR_W-1:0]  left_i,
  input  logic [ADDR_W-1:0]  right_i,
  input  logic [ADDR_W-1:0]  parent_i,
  input  logic               xfer_done,
  output logic               tr_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               done_o
);
  logic              capture, is_root, is_leaf;
  logic [ADDR_W-1:0] left_eff, right_eff, parent_eff;
  seq_state_t        state_q, state_nxt;

  tree_seq_cfg #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) u_cfg (
    .clk(clk), .rst(rst), .capture(capture), .level_i(level_i),
    .left_i(left_i), .right_i(right_i), .parent_i(parent_i),
    .is_root(is_root), .is_leaf(is_leaf),
    .left_eff(left_eff), .right_eff(right_eff), .parent_eff(parent_eff)
  );

  tree_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .xfer_done(xfer_done),
    .is_root(is_root), .is_leaf(is_leaf), .capture(capture),
    .state_q(state_q), .state_nxt(state_nxt)
  );

  tree_seq_out #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt),
    .left_eff(left_eff), .right_eff(right_eff), .parent_eff(parent_eff),
    .tr_o(tr_o), .addr_o(addr_o), .done_o(done_o)
  );

  // R4
  root_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && is_root) |-> !tr_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_tree_node_seq.sv
module tb_tree_node_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] level = '0;
  logic [3:0] left_a = '0, right_a = '0, parent_a = '0;
  logic       xfer = 1'b0;
  logic       tr;
  logic [3:0] addr;
  logic       done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tree_node_seq dut (
    .clk(clk), .rst(rst), .start(start), .level_i(level),
    .left_i(left_a), .right_i(right_a), .parent_i(parent_a),
    .xfer_done(xfer), .tr_o(tr), .addr_o(addr), .done_o(done)
  );

  // {level, left, right, parent}
  localparam logic [13:0] VECS [0:7] = '{
    {2'd1, 4'h2, 4'h4, 4'h0},
    {2'd2, 4'h3, 4'h5, 4'h1},
    {2'd3, 4'hA, 4'hB, 4'h2},
    {2'd0, 4'h1, 4'h9, 4'hF},
    {2'd2, 4'h7, 4'hF, 4'h4},
    {2'd3, 4'h0, 4'h0, 4'hE},
    {2'd0, 4'hC, 4'h0, 4'h0},
    {2'd1, 4'hF, 4'h0, 4'h8}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_round(input logic [1:0] lv, input logic [3:0] l,
                           input logic [3:0] r, input logic [3:0] p);
    string tag;
    int    n;
    logic  etr [3];
    logic [3:0] ead [3];
    tag = (lv == 2'd3) ? "R3" : (lv == 2'd0) ? "R4" : "R2";
    if (lv == 2'd3) begin n = 1; etr[0] = 1; ead[0] = p; end
    else if (lv == 2'd0) begin n = 1; etr[0] = 0; ead[0] = l; end
    else begin
      n = 3;
      etr[0] = 0; ead[0] = l;
      etr[1] = 0; ead[1] = r;
      etr[2] = 1; ead[2] = p;
    end
    level = lv; left_a = l; right_a = r; parent_a = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble the inputs after the start edge
    level = ~lv; left_a = ~l; right_a = ~r; parent_a = ~p;
    for (int i = 0; i < n; i++) begin
      chk({tag, " tr"}, tr, etr[i]);
      chk({tag, " R9 addr"}, addr, ead[i]);
      chk({tag, " done low"}, done, 0);
      @(negedge clk);
      chk("R5 hold addr", addr, ead[i]);
      xfer = 1'b1;
      @(negedge clk);
      xfer = 1'b0;
    end
    chk("R6 done high", done, 1);
    chk("R6 tr held", tr, etr[n-1]);
    chk("R6 addr held", addr, ead[n-1]);
    @(negedge clk);
    chk("R6 done low", done, 0);
    chk("R6 idle tr", tr, 0);
    chk("R6 idle addr", addr, 0);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tr", tr, 0);
    chk("R1 reset addr", addr, 0);
    chk("R1 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 8; v++)
      run_round(VECS[v][13:12], VECS[v][11:8], VECS[v][7:4], VECS[v][3:0]);

    // R8: completion in idle does nothing
    xfer = 1'b1;
    repeat (2) @(negedge clk);
    xfer = 1'b0;
    chk("R8 idle addr", addr, 0);
    chk("R8 idle done", done, 0);

    // R8: start and completion in the same cycle
    level = 2'd1; left_a = 4'h6; right_a = 4'h7; parent_a = 4'h3;
    start = 1'b1; xfer = 1'b1;
    @(negedge clk);
    start = 1'b0; xfer = 1'b0;
    chk("R8 first step kept", addr, 6);
    @(negedge clk);
    chk("R8 still left", addr, 6);
    // R7: start mid-round is ignored
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 mid-round addr", addr, 7);
    chk("R7 mid-round tr", tr, 0);
    // R1: reset abandons the round
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset addr", addr, 0);
    chk("R1 mid reset done", done, 0);

    // R7: start during the done cycle is ignored
    level = 2'd3; parent_a = 4'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 leaf tr", tr, 1);
    xfer = 1'b1;
    @(negedge clk);
    xfer = 1'b0;
    chk("R6 leaf done", done, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done-cycle start tr", tr, 0);
    chk("R7 done-cycle start addr", addr, 0);
    @(negedge clk);
    chk("R7 stays idle", addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule